// File: doc/BRIEF.md
# Host Bus Bridge with Memory Wait-States

This block sits between a synchronous host processor port and two targets. The first is a small internal register file. The second is an external backing memory reached through a request/grant handshake. An access starts when chip select is low together with a read strobe or at least one of the two byte-lane write strobes. A region-select input picks the target: low selects the register file, addressed by the three low address bits, and high selects the backing memory, addressed by the full 16-bit address.

Register accesses finish without stalling the host. A backing-memory access holds the active-low wait output low for a fixed minimum number of cycles, and longer if the memory is slow to grant or holds its own wait. If the memory does not finish within a parameterized limit, the access is aborted. A sticky failure flag and the interrupt output are then raised, and both stay high until the host writes the status register. A data-enable output marks the cycles in which read data is being driven, so that an external tristate buffer can be enabled.

Top module: `hostbus_bridge`

## Requirements
- R1: While the synchronous active-low reset `rst_n` is sampled low, the outputs settle to `host_wait_n`=1, `mem_req_n`=1, `irq`=0, `mem_fail`=0 and `host_rd_en`=0.
- R2: In the register region, `host_wr_n[1]`=0 writes data bits [15:8] and `host_wr_n[0]`=0 writes bits [7:0] of the register selected by `host_addr[2:0]`. A lane whose strobe is high keeps its old value.
- R3: Register-region accesses never pull `host_wait_n` low. Read data appears on `host_rdata`, with `host_rd_en` high, from the cycle after the strobe starts until the strobe is released.
- R4: With a memory that completes at once, a backing-memory read keeps `host_wait_n` low for exactly 4 cycles and a write for exactly 3. These counts are the lower limits in every case.
- R5: The memory completes an access in a cycle where `mem_req_n`, `mem_gnt_n` are low and `mem_wait_n` is high. `host_wait_n` is released at the later of the minimum and that completion cycle, counted from the start edge.
- R6: While `mem_req_n` is low, the memory port carries the host address, the write data, `mem_be` = inverted write strobes (2'b11 for reads) and `mem_rnw` (1 = read). Read data taken at completion is returned on `host_rdata`.
- R7: If no completion occurs within `TMO_LIM` (16) cycles of the start edge, `host_wait_n` is released and `mem_req_n` is dropped on that edge. Read data returns 0x0000, and `mem_fail` and `irq` go high.
- R8: Register 7 reads as bit 0 = `irq` and bit 1 = `mem_fail`. A host write to register 7 with either lane clears both, and they stay high until then.
- R9: A new access starts only when the chip-select-and-strobe condition becomes true. A strobe held after completion does not issue a second memory request.
- R10: `host_rd_en` stays low during write accesses and is high only while `host_wait_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous reset, active low |
| host_cs_n | input | 1 | Chip select, active low |
| host_rd_n | input | 1 | Read strobe, active low |
| host_wr_n | input | 2 | Byte-lane write strobes, active low |
| host_region | input | 1 | 0 = register file, 1 = backing memory |
| host_addr | input | 16 | Host address |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data |
| host_rd_en | output | 1 | High while read data is driven |
| host_wait_n | output | 1 | Stall, active low |
| irq | output | 1 | Interrupt, active high |
| mem_fail | output | 1 | Sticky backing-memory timeout flag |
| mem_req_n | output | 1 | Memory request, active low |
| mem_gnt_n | input | 1 | Memory grant, active low |
| mem_wait_n | input | 1 | Memory wait, active low |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 16 | Memory write data |
| mem_be | output | 2 | Memory byte enables |
| mem_rnw | output | 1 | 1 = read, 0 = write |
| mem_rdata | input | 16 | Memory read data |

## Verification
A faulty elapsed counter or completion latch in the sequencer shows up on the first backing-memory access. The stall length differs from the later of the minimum and the completion edge, so the stall-length scoreboard reports it in the same access. A stuck timeout counter shows within the limit plus one cycle, as a stall that is too long or too short, a nonzero read word, or failure and interrupt flags that disagree. A broken start detector or byte-lane decode shows on the next readback, as a wrong register or memory word or as an extra request while the strobe is held.

// File: rtl/hb_pkg.sv
package hb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MEM  = 2'd1,
    ST_HOLD = 2'd2
  } seq_st_t;
endpackage

// File: rtl/hb_edge_det.sv
module hb_edge_det (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       rd_n,
  input  logic [1:0] wr_n,
  output logic       act,
  output logic       start,
  output logic       is_rd
);
  logic act_q;

  assign act   = !cs_n && (!rd_n || (wr_n != 2'b11));
  assign start = act && !act_q;
  assign is_rd = !rd_n;

  always_ff @(posedge clk) begin
    if (!rst_n) act_q <= 1'b0;
    else        act_q <= act;
  end
endmodule

// File: rtl/hb_regfile.sv
module hb_regfile #(
  parameter int AW = 3,
  parameter int DW = 16
) (
  input  logic               clk,
  input  logic [DW/8-1:0]    we,
  input  logic [AW-1:0]      waddr,
  input  logic [DW-1:0]      wdata,
  input  logic [AW-1:0]      raddr,
  output logic [DW-1:0]      rdata
);
  localparam int DEPTH = 1 << AW;
  localparam int LANES = DW / 8;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [7:0] lane_mem [DEPTH];
    always_ff @(posedge clk) begin
      if (we[l]) lane_mem[waddr] <= wdata[l*8 +: 8];
    end
    assign rdata[l*8 +: 8] = lane_mem[raddr];
  end
endmodule

// File: rtl/hb_mem_seq.sv
module hb_mem_seq
  import hb_pkg::*;
#(
  parameter int AW      = 16,
  parameter int DW      = 16,
  parameter int MIN_RD  = 4,
  parameter int MIN_WR  = 3,
  parameter int TMO_LIM = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            act,
  input  logic            region,
  input  logic            is_rd,
  input  logic [1:0]      byte_wr,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   wdata,
  input  logic            clr_flags,
  input  logic            mem_gnt_n,
  input  logic            mem_wait_n,
  input  logic [DW-1:0]   mem_rdata,
  output logic            host_wait_n,
  output logic            mem_req_n,
  output logic [AW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata,
  output logic [1:0]      mem_be,
  output logic            mem_rnw,
  output logic            irq,
  output logic            mem_fail,
  output logic            fin,
  output logic [DW-1:0]   fin_data
);
  localparam int EW     = $clog2(TMO_LIM + 2);
  localparam int TW     = $clog2(TMO_LIM + 1);
  localparam int EL_MAX = (1 << EW) - 1;

  seq_st_t        state;
  logic [EW-1:0]  el;
  logic [TW-1:0]  tmo;
  logic           done_q;
  logic [DW-1:0]  cap_q;
  logic [EW-1:0]  mlim;
  logic           cmp_now;
  logic           abort_now;
  logic           rel_now;

  assign mlim      = mem_rnw ? EW'(MIN_RD) : EW'(MIN_WR);
  assign cmp_now   = (state == ST_MEM) && !mem_req_n && !mem_gnt_n && mem_wait_n;
  assign abort_now = (state == ST_MEM) && !mem_req_n && !cmp_now && (tmo == TW'(TMO_LIM - 1));
  assign rel_now   = (state == ST_MEM) && (done_q || cmp_now) && (el >= mlim);
  assign fin       = rel_now || abort_now;
  assign fin_data  = abort_now ? '0 : (done_q ? cap_q : mem_rdata);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      el          <= '0;
      tmo         <= '0;
      done_q      <= 1'b0;
      cap_q       <= '0;
      host_wait_n <= 1'b1;
      mem_req_n   <= 1'b1;
      mem_addr    <= '0;
      mem_wdata   <= '0;
      mem_be      <= 2'b00;
      mem_rnw     <= 1'b1;
      irq         <= 1'b0;
      mem_fail    <= 1'b0;
    end else begin
      if (abort_now) begin
        irq      <= 1'b1;
        mem_fail <= 1'b1;
      end else if (clr_flags) begin
        irq      <= 1'b0;
        mem_fail <= 1'b0;
      end

      case (state)
        ST_IDLE: begin
          if (start) begin
            if (region) begin
              state       <= ST_MEM;
              el          <= EW'(1);
              tmo         <= '0;
              done_q      <= 1'b0;
              host_wait_n <= 1'b0;
              mem_req_n   <= 1'b0;
              mem_addr    <= addr;
              mem_wdata   <= wdata;
              mem_rnw     <= is_rd;
              mem_be      <= is_rd ? 2'b11 : byte_wr;
            end else begin
              state <= ST_HOLD;
            end
          end
        end
        ST_MEM: begin
          if (el != EW'(EL_MAX)) el <= el + EW'(1);
          if (cmp_now) begin
            mem_req_n <= 1'b1;
            done_q    <= 1'b1;
            cap_q     <= mem_rdata;
          end else if (abort_now) begin
            mem_req_n <= 1'b1;
          end else if (!mem_req_n) begin
            tmo <= tmo + TW'(1);
          end
          if (rel_now || abort_now) begin
            host_wait_n <= 1'b1;
            state       <= ST_HOLD;
          end
        end
        ST_HOLD: begin
          if (!act) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_no_wait_reg_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && start && !region) |=> host_wait_n);

  assert_min_wait_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_MEM && !host_wait_n && el < mlim) |=> !host_wait_n);

  assert_addr_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_req_n && $past(!mem_req_n)) |-> $stable(mem_addr));

  assert_req_dropped_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(host_wait_n) |-> mem_req_n);

  assert_fail_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_fail && !clr_flags) |=> mem_fail);

  assert_no_rerequest_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HOLD && act) |=> mem_req_n);
endmodule

// File: rtl/hostbus_bridge.sv
module hostbus_bridge #(
  parameter int AW       = 16,
  parameter int DW       = 16,
  parameter int REG_AW   = 3,
  parameter int STAT_IDX = 7,
  parameter int MIN_RD   = 4,
  parameter int MIN_WR   = 3,
  parameter int TMO_LIM  = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_cs_n,
  input  logic          host_rd_n,
  input  logic [1:0]    host_wr_n,
  input  logic          host_region,
  input  logic [15:0]   host_addr,
  input  logic [15:0]   host_wdata,
  output logic [15:0]   host_rdata,
  output logic          host_rd_en,
  output logic          host_wait_n,
  output logic          irq,
  output logic          mem_fail,
  output logic          mem_req_n,
  input  logic          mem_gnt_n,
  input  logic          mem_wait_n,
  output logic [15:0]   mem_addr,
  output logic [15:0]   mem_wdata,
  output logic [1:0]    mem_be,
  output logic          mem_rnw,
  input  logic [15:0]   mem_rdata
);
  logic          act, start, is_rd;
  logic          reg_hit, stat_hit, rd_start, clr_flags, fin;
  logic [1:0]    byte_wr;
  logic [1:0]    rf_we;
  logic [DW-1:0] rf_rdata, reg_word, fin_data;

  hb_edge_det u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .cs_n  (host_cs_n),
    .rd_n  (host_rd_n),
    .wr_n  (host_wr_n),
    .act   (act),
    .start (start),
    .is_rd (is_rd)
  );

  assign byte_wr   = ~host_wr_n;
  assign reg_hit   = start && !host_region;
  assign stat_hit  = (host_addr[REG_AW-1:0] == REG_AW'(STAT_IDX));
  assign rd_start  = reg_hit && is_rd;
  assign rf_we     = (reg_hit && !is_rd) ? byte_wr : 2'b00;
  assign clr_flags = reg_hit && !is_rd && (byte_wr != 2'b00) && stat_hit;

  hb_regfile #(.AW(REG_AW), .DW(DW)) u_rf (
    .clk   (clk),
    .we    (rf_we),
    .waddr (host_addr[REG_AW-1:0]),
    .wdata (host_wdata),
    .raddr (host_addr[REG_AW-1:0]),
    .rdata (rf_rdata)
  );

  assign reg_word = stat_hit ? {{(DW-2){1'b0}}, mem_fail, irq} : rf_rdata;

  hb_mem_seq #(
    .AW(AW), .DW(DW), .MIN_RD(MIN_RD), .MIN_WR(MIN_WR), .TMO_LIM(TMO_LIM)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .act         (act),
    .region      (host_region),
    .is_rd       (is_rd),
    .byte_wr     (byte_wr),
    .addr        (host_addr),
    .wdata       (host_wdata),
    .clr_flags   (clr_flags),
    .mem_gnt_n   (mem_gnt_n),
    .mem_wait_n  (mem_wait_n),
    .mem_rdata   (mem_rdata),
    .host_wait_n (host_wait_n),
    .mem_req_n   (mem_req_n),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata),
    .mem_be      (mem_be),
    .mem_rnw     (mem_rnw),
    .irq         (irq),
    .mem_fail    (mem_fail),
    .fin         (fin),
    .fin_data    (fin_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      host_rdata <= '0;
      host_rd_en <= 1'b0;
    end else if (rd_start) begin
      host_rdata <= reg_word;
      host_rd_en <= 1'b1;
    end else if (fin && mem_rnw) begin
      host_rdata <= fin_data;
      host_rd_en <= 1'b1;
    end else if (!act) begin
      host_rd_en <= 1'b0;
    end
  end

  assert_rden_no_wait_R10: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd_en |-> host_wait_n);

  assert_rden_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !is_rd) |=> !host_rd_en);
endmodule

// File: tb/sim_hostbus_bridge.sv
module sim_hostbus_bridge;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_cs_n = 1'b1, host_rd_n = 1'b1, host_region = 1'b0;
  logic [1:0]  host_wr_n = 2'b11;
  logic [15:0] host_addr = '0, host_wdata = '0;
  logic [15:0] host_rdata;
  logic        host_rd_en, host_wait_n, irq, mem_fail, mem_req_n, mem_rnw;
  logic        mem_gnt_n, mem_wait_n;
  logic [15:0] mem_addr, mem_wdata, mem_rdata;
  logic [1:0]  mem_be;

  int checks = 0, failures = 0;
  bit finished = 0;
  int gd = 0, wc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hostbus_bridge u0 (
    .clk(clk), .rst_n(rst_n), .host_cs_n(host_cs_n), .host_rd_n(host_rd_n),
    .host_wr_n(host_wr_n), .host_region(host_region), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .host_rd_en(host_rd_en),
    .host_wait_n(host_wait_n), .irq(irq), .mem_fail(mem_fail),
    .mem_req_n(mem_req_n), .mem_gnt_n(mem_gnt_n), .mem_wait_n(mem_wait_n),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_be(mem_be),
    .mem_rnw(mem_rnw), .mem_rdata(mem_rdata)
  );

  // backing memory model
  logic [15:0] bmem [16];
  int gcnt = 0, wcnt = 0;
  assign mem_rdata = bmem[mem_addr[3:0]];

  always_ff @(posedge clk) begin
    if (!rst_n || mem_req_n) begin
      mem_gnt_n  <= 1'b1;
      mem_wait_n <= 1'b1;
      gcnt       <= 0;
    end else if (mem_gnt_n) begin
      if (gcnt == gd) begin
        mem_gnt_n  <= 1'b0;
        mem_wait_n <= (wc == 0);
        wcnt       <= wc;
      end else begin
        gcnt <= gcnt + 1;
      end
    end else begin
      if (mem_wait_n && !mem_rnw) begin
        if (mem_be[1]) bmem[mem_addr[3:0]][15:8] <= mem_wdata[15:8];
        if (mem_be[0]) bmem[mem_addr[3:0]][7:0]  <= mem_wdata[7:0];
      end
      if (!mem_wait_n) begin
        if (wcnt > 1) wcnt <= wcnt - 1;
        else          mem_wait_n <= 1'b1;
      end
    end
  end

  task automatic chk(string tag, logic [31:0] act_v, logic [31:0] exp_v);
    checks++;
    if (act_v !== exp_v) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act_v, exp_v);
    end
  endtask

  // scoreboard queues
  int    exp_wait_q[$];
  string wait_tag_q[$];
  int    exp_rd_q[$];
  string rd_tag_q[$];

  task automatic push_wait(string tag, int n);
    exp_wait_q.push_back(n);
    wait_tag_q.push_back(tag);
  endtask

  task automatic push_rd(string tag, int v);
    exp_rd_q.push_back(v);
    rd_tag_q.push_back(tag);
  endtask

  // monitor
  initial begin
    int  run = 0;
    bit  prev_rd = 0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (!host_wait_n) run++;
        else if (run > 0) begin
          if (exp_wait_q.size() == 0) chk("R3 unexpected stall", run, 0);
          else chk({wait_tag_q.pop_front(), " stall length"}, run, exp_wait_q.pop_front());
          run = 0;
        end
        if (host_rd_en && !prev_rd) begin
          if (exp_rd_q.size() == 0) chk("R10 unexpected read enable", 1, 0);
          else chk({rd_tag_q.pop_front(), " read data"}, host_rdata, exp_rd_q.pop_front());
        end
        prev_rd = host_rd_en;
      end
    end
  end

  task automatic host_acc(input logic region, input logic rd, input logic [1:0] wrn,
                          input logic [15:0] addr, input logic [15:0] data, input int hold);
    @(negedge clk);
    host_cs_n   = 1'b0;
    host_region = region;
    host_addr   = addr;
    host_wdata  = data;
    host_rd_n   = !rd;
    host_wr_n   = rd ? 2'b11 : wrn;
    @(negedge clk);
    if (!rd) chk("R10 rd_en low on write", host_rd_en, 0);
    while (!host_wait_n) @(negedge clk);
    for (int i = 0; i < hold; i++) begin
      if (region) chk("R9 no request while strobe held", mem_req_n, 1);
      @(negedge clk);
    end
    host_cs_n = 1'b1;
    host_rd_n = 1'b1;
    host_wr_n = 2'b11;
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog all-requirements actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) bmem[i] = '0;
    repeat (3) @(negedge clk);
    // R1 reset values
    chk("R1 wait_n", host_wait_n, 1);
    chk("R1 req_n", mem_req_n, 1);
    chk("R1 irq", irq, 0);
    chk("R1 fail", mem_fail, 0);
    chk("R1 rd_en", host_rd_en, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 byte lanes in register file
    host_acc(0, 0, 2'b00, 16'h0002, 16'hA5C3, 1);
    host_acc(0, 0, 2'b01, 16'h0002, 16'h12FF, 1);
    push_rd("R2 upper lane", 16'h12C3);
    host_acc(0, 1, 2'b11, 16'h0002, 16'h0000, 1);
    host_acc(0, 0, 2'b10, 16'h0002, 16'hEE77, 1);
    host_acc(0, 0, 2'b00, 16'h0003, 16'hBEEF, 1);
    push_rd("R2 lower lane", 16'h1277);
    host_acc(0, 1, 2'b11, 16'h0002, 16'h0000, 1);
    push_rd("R3 register read", 16'hBEEF);
    host_acc(0, 1, 2'b11, 16'h0003, 16'h0000, 3);

    // R4 minimum waits, R6 port content
    gd = 0; wc = 0;
    push_wait("R4 write min", 3);
    host_acc(1, 0, 2'b00, 16'h0005, 16'h5A5A, 1);
    chk("R6 memory word 5", bmem[5], 16'h5A5A);
    push_wait("R4 read min", 4);
    push_rd("R6 memory read", 16'h5A5A);
    host_acc(1, 1, 2'b11, 16'h0005, 16'h0000, 1);
    push_wait("R4 write min", 3);
    host_acc(1, 0, 2'b00, 16'h0006, 16'hFFFF, 1);
    push_wait("R4 write min", 3);
    host_acc(1, 0, 2'b10, 16'h0006, 16'h0011, 1);
    chk("R6 byte enable lower", bmem[6], 16'hFF11);

    // R5 extension by grant latency and memory wait
    gd = 3; wc = 2;
    push_wait("R5 delayed read", 7);
    push_rd("R5 delayed read", 16'hFF11);
    host_acc(1, 1, 2'b11, 16'h0006, 16'h0000, 1);
    gd = 2; wc = 0;
    push_wait("R5 delayed write", 4);
    host_acc(1, 0, 2'b00, 16'h0007, 16'h1234, 1);
    chk("R5 delayed write data", bmem[7], 16'h1234);
    gd = 0; wc = 1;
    push_wait("R5 wait within min", 3);
    host_acc(1, 0, 2'b00, 16'h0008, 16'h4321, 1);
    chk("R5 write data", bmem[8], 16'h4321);

    // R7 grant timeout
    gd = 100; wc = 0;
    push_wait("R7 grant timeout", 16);
    push_rd("R7 timeout data", 16'h0000);
    host_acc(1, 1, 2'b11, 16'h0005, 16'h0000, 1);
    chk("R7 fail", mem_fail, 1);
    chk("R7 irq", irq, 1);
    chk("R7 req dropped", mem_req_n, 1);

    // R8 status read and clear
    push_rd("R8 status set", 16'h0003);
    host_acc(0, 1, 2'b11, 16'h0007, 16'h0000, 1);
    chk("R8 fail sticky", mem_fail, 1);
    host_acc(0, 0, 2'b10, 16'h0007, 16'h0000, 1);
    chk("R8 irq cleared", irq, 0);
    chk("R8 fail cleared", mem_fail, 0);
    push_rd("R8 status clear", 16'h0000);
    host_acc(0, 1, 2'b11, 16'h0007, 16'h0000, 1);

    // R7 memory wait held too long
    gd = 0; wc = 20;
    push_wait("R7 wait timeout", 16);
    host_acc(1, 0, 2'b00, 16'h0009, 16'hDEAD, 1);
    chk("R7 fail on wait", mem_fail, 1);
    chk("R7 no write on abort", bmem[9], 16'h0000);
    host_acc(0, 0, 2'b01, 16'h0007, 16'h0000, 1);
    chk("R8 upper lane clears", mem_fail, 0);

    // R9 held strobe
    gd = 0; wc = 0;
    push_wait("R9 held read", 4);
    push_rd("R9 held read", 16'h5A5A);
    host_acc(1, 1, 2'b11, 16'h0005, 16'h0000, 6);

    repeat (4) @(negedge clk);
    chk("R4 all stalls seen", exp_wait_q.size(), 0);
    chk("R3 all reads seen", exp_rd_q.size(), 0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule